// File: doc/BRIEF.md
# Array Configuration Cache and Loader

This block sits between a host processor and a row-organised reconfigurable array. The host names a configuration by an identifier and asks for it to be loaded. The loader then writes that configuration, one bus-wide word at a time, into the array's configuration store. A few complete configurations are kept in an on-chip cache. A configuration that is already cached is copied from there with no external memory traffic. Any other configuration is fetched from external memory, and the fetch also refills one cache slot. A load may cover only a band of rows, which gives partial reconfiguration.

Once a configuration is in place, the host starts execution with an iteration count. The array runs for that many cycles and then stalls until it is started again. A start that arrives while a load is in progress is held and issued when the load completes. The array holds only one configuration at a time, and the loader reports which one.

With default parameters a row has 24 elements of 64 configuration bits each, which is twelve 128-bit words. Four rows make 48 words per configuration, and the cache holds four configurations.

Top module: `cfg_cache_loader`

## Requirements
- R1: After reset, `busy`, `array_run`, `array_stall`, `cfg_we`, `mem_rd_req` and `active_valid` are low and every cache slot is empty, so the first load of any identifier is a miss.
- R2: On a miss the loader makes exactly WORDS memory transfers. While `mem_rd_req` is high, `mem_rd_addr` is `{id, k}`: the identifier in the upper ID_W bits and the word index k (IDXW bits, rising from 0 to WORDS-1) in the lower bits. The address stays stable until `mem_rd_valid` is seen, and each cycle with `mem_rd_valid` high completes one transfer.
- R3: Array writes go out in rising order. Each write has `cfg_addr` = row*WPR + word-in-row and `cfg_wdata` equal to the configuration word with that index. Only rows from `cmd_row_first` to `cmd_row_last` inclusive are written. A range with first > last writes nothing.
- R4: A load whose identifier is cached (a hit) produces the same array writes as a miss and raises `mem_rd_req` in no cycle.
- R5: A miss overwrites the slot that was filled least recently. A hit does not change the replacement order.
- R6: `busy` is high while a load is in progress. A load command that arrives while `busy` is high is ignored.
- R7: A start command with a nonzero count N makes `array_run` high for exactly N consecutive cycles, starting with the cycle after the command is accepted. After that `array_stall` is high until the next start. `array_run` and `array_stall` are never high together.
- R8: A start with a count of zero raises `array_stall` in the next cycle, and `array_run` stays low.
- R9: A start command that arrives while `busy` is high is held and issued when the load completes. `array_run` stays low until then, and the held start then runs its full count.
- R10: While `array_run` is high, a load command is ignored: no memory request, no array write, and `active_id` is unchanged. `active_id` shows the identifier of the most recently accepted load, and `active_valid` marks it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_is_start | input | 1 | 1 = start execution, 0 = load configuration |
| cmd_cfg_id | input | ID_W | Identifier of the configuration to load |
| cmd_row_first | input | ROW_W | First row to write |
| cmd_row_last | input | ROW_W | Last row to write (inclusive) |
| cmd_iter | input | ITER_W | Iteration count for a start |
| busy | output | 1 | A load is in progress |
| array_run | output | 1 | Array executes this cycle |
| array_stall | output | 1 | Iteration count has expired |
| active_id | output | ID_W | Identifier of the configuration in the array |
| active_valid | output | 1 | `active_id` is meaningful |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ID_W+IDXW | Memory word address `{id, index}` |
| mem_rd_valid | input | 1 | Read data valid; completes one transfer |
| mem_rd_data | input | BUS_W | Read data |
| cfg_we | output | 1 | Configuration write enable |
| cfg_addr | output | IDXW | Word index in the array's configuration store |
| cfg_wdata | output | BUS_W | Configuration word |

## Verification
A wrong tag, valid bit or victim pointer shows at the ports on the very next load of the affected identifier. A hit raises `mem_rd_req` when it should not, or a miss returns without any memory traffic, and either can be seen within one cycle of the command. Corrupted cache contents show up as a wrong `cfg_wdata` on the first write that reads the damaged word. An off-by-one in the iteration counter makes `array_run` one cycle too long or too short, so the fault is visible N+1 cycles after the start. A lost held start leaves `array_run` low after `busy` falls.

// File: rtl/cfg_cache_loader_pkg.sv
package cfg_cache_loader_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_COPY  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/cfg_slot_store.sv
module cfg_slot_store #(
    parameter int SLOTS  = 4,
    parameter int WORDS  = 48,
    parameter int DATA_W = 128,
    localparam int SLW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDXW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLW-1:0]    wr_slot,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLW-1:0]    rd_slot,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = SLOTS * WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[int'(wr_slot) * WORDS + int'(wr_idx)] <= wr_data;
        end
    end

    assign rd_data = mem_q[int'(rd_slot) * WORDS + int'(rd_idx)];

endmodule

// File: rtl/cfg_iter_ctrl.sv
module cfg_iter_ctrl #(
    parameter int ITER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ITER_W-1:0] start_val,
    output logic              run,
    output logic              stall
);

    typedef struct packed {
        logic [ITER_W-1:0] cnt;
        logic              run;
        logic              stall;
    } iter_t;

    iter_t it_d, it_q;

    always_comb begin
        it_d = it_q;
        if (start) begin
            if (start_val == '0) begin
                it_d.cnt   = '0;
                it_d.run   = 1'b0;
                it_d.stall = 1'b1;
            end else begin
                it_d.cnt   = start_val;
                it_d.run   = 1'b1;
                it_d.stall = 1'b0;
            end
        end else if (it_q.run) begin
            if (it_q.cnt == ITER_W'(1)) begin
                it_d.cnt   = '0;
                it_d.run   = 1'b0;
                it_d.stall = 1'b1;
            end else begin
                it_d.cnt = it_q.cnt - ITER_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            it_q <= '0;
        end else begin
            it_q <= it_d;
        end
    end

    assign run   = it_q.run;
    assign stall = it_q.stall;

endmodule

// File: rtl/cfg_cache_loader.sv
module cfg_cache_loader
    import cfg_cache_loader_pkg::*;
#(
    parameter int ROWS        = 4,
    parameter int PES_PER_ROW = 24,
    parameter int PE_CFG_BITS = 64,
    parameter int BUS_W       = 128,
    parameter int SLOTS       = 4,
    parameter int ID_W        = 8,
    parameter int ITER_W      = 16,
    localparam int WPR        = (PES_PER_ROW * PE_CFG_BITS) / BUS_W,
    localparam int WORDS      = ROWS * WPR,
    localparam int IDXW       = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_is_start,
    input  logic [ID_W-1:0]      cmd_cfg_id,
    input  logic [ROW_W-1:0]     cmd_row_first,
    input  logic [ROW_W-1:0]     cmd_row_last,
    input  logic [ITER_W-1:0]    cmd_iter,
    output logic                 busy,
    output logic                 array_run,
    output logic                 array_stall,
    output logic [ID_W-1:0]      active_id,
    output logic                 active_valid,
    output logic                 mem_rd_req,
    output logic [ID_W+IDXW-1:0] mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [BUS_W-1:0]     mem_rd_data,
    output logic                 cfg_we,
    output logic [IDXW-1:0]      cfg_addr,
    output logic [BUS_W-1:0]     cfg_wdata
);

    localparam int SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int WPW = (WPR > 1) ? $clog2(WPR) : 1;

    typedef struct packed {
        ld_state_e                  st;
        logic [SLW-1:0]             slot;
        logic [ROW_W-1:0]           row;
        logic [WPW-1:0]             wrd;
        logic [IDXW-1:0]            idx;
        logic [ROW_W-1:0]           first;
        logic [ROW_W-1:0]           last;
        logic [ID_W-1:0]            id;
        logic                       pend;
        logic [ITER_W-1:0]          pend_iter;
        logic [SLW-1:0]             victim;
        logic [SLOTS-1:0]           vld;
        logic [SLOTS-1:0][ID_W-1:0] tag;
        logic                       we;
        logic [IDXW-1:0]            waddr;
        logic [BUS_W-1:0]           wdata;
        logic [ID_W-1:0]            act_id;
        logic                       act_vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SLOTS-1:0]  slot_match;
    logic              hit;
    logic [SLW-1:0]    hit_slot;
    logic [ROW_W-1:0]  last_clip;
    logic              in_range;
    logic              row_end;
    logic              iter_start;
    logic [ITER_W-1:0] iter_val;
    logic              iter_run;
    logic              iter_stall;
    logic              st_wr_en;
    logic [BUS_W-1:0]  st_rd_data;

    // per-slot tag comparison
    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_match
            assign slot_match[g] = ctl_q.vld[g] && (ctl_q.tag[g] == cmd_cfg_id);
        end
    endgenerate

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_match[s]) begin
                hit      = 1'b1;
                hit_slot = SLW'(s);
            end
        end
    end

    assign last_clip = (cmd_row_last > ROW_W'(ROWS - 1)) ? ROW_W'(ROWS - 1) : cmd_row_last;
    assign in_range  = (ctl_q.row >= ctl_q.first) && (ctl_q.row <= ctl_q.last);
    assign row_end   = (ctl_q.wrd == WPW'(WPR - 1));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.we   = 1'b0;
        iter_start = 1'b0;
        iter_val   = cmd_iter;
        st_wr_en   = 1'b0;

        // hold a start that arrives during a load
        if (ctl_q.st != LD_IDLE && cmd_valid && cmd_is_start) begin
            ctl_d.pend      = 1'b1;
            ctl_d.pend_iter = cmd_iter;
        end

        unique case (ctl_q.st)
            LD_IDLE: begin
                if (ctl_q.pend) begin
                    iter_start = 1'b1;
                    iter_val   = ctl_q.pend_iter;
                    ctl_d.pend = 1'b0;
                end else if (cmd_valid && cmd_is_start) begin
                    iter_start = 1'b1;
                end else if (cmd_valid && !iter_run) begin
                    ctl_d.id      = cmd_cfg_id;
                    ctl_d.first   = cmd_row_first;
                    ctl_d.last    = last_clip;
                    ctl_d.act_id  = cmd_cfg_id;
                    ctl_d.act_vld = 1'b1;
                    ctl_d.wrd     = '0;
                    if (hit) begin
                        ctl_d.slot = hit_slot;
                        ctl_d.row  = cmd_row_first;
                        ctl_d.idx  = IDXW'(int'(cmd_row_first) * WPR);
                        if (cmd_row_first <= last_clip) begin
                            ctl_d.st = LD_COPY;
                        end
                    end else begin
                        ctl_d.slot             = ctl_q.victim;
                        ctl_d.vld[ctl_q.victim] = 1'b0;
                        ctl_d.row              = '0;
                        ctl_d.idx              = '0;
                        ctl_d.st               = LD_FETCH;
                    end
                end
            end

            LD_FETCH: begin
                if (mem_rd_valid) begin
                    st_wr_en    = 1'b1;
                    ctl_d.we    = in_range;
                    ctl_d.waddr = ctl_q.idx;
                    ctl_d.wdata = mem_rd_data;
                    ctl_d.idx   = ctl_q.idx + IDXW'(1);
                    if (row_end) begin
                        ctl_d.wrd = '0;
                        ctl_d.row = ctl_q.row + ROW_W'(1);
                    end else begin
                        ctl_d.wrd = ctl_q.wrd + WPW'(1);
                    end
                    if (ctl_q.idx == IDXW'(WORDS - 1)) begin
                        ctl_d.vld[ctl_q.slot] = 1'b1;
                        ctl_d.tag[ctl_q.slot] = ctl_q.id;
                        ctl_d.victim = (ctl_q.victim == SLW'(SLOTS - 1)) ? '0
                                     : ctl_q.victim + SLW'(1);
                        ctl_d.st     = LD_IDLE;
                    end
                end
            end

            LD_COPY: begin
                ctl_d.we    = 1'b1;
                ctl_d.waddr = ctl_q.idx;
                ctl_d.wdata = st_rd_data;
                ctl_d.idx   = ctl_q.idx + IDXW'(1);
                if (row_end) begin
                    ctl_d.wrd = '0;
                    ctl_d.row = ctl_q.row + ROW_W'(1);
                end else begin
                    ctl_d.wrd = ctl_q.wrd + WPW'(1);
                end
                if (row_end && ctl_q.row == ctl_q.last) begin
                    ctl_d.st = LD_IDLE;
                end
            end

            default: ctl_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cfg_slot_store #(
        .SLOTS (SLOTS),
        .WORDS (WORDS),
        .DATA_W(BUS_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (st_wr_en),
        .wr_slot(ctl_q.slot),
        .wr_idx (ctl_q.idx),
        .wr_data(mem_rd_data),
        .rd_slot(ctl_q.slot),
        .rd_idx (ctl_q.idx),
        .rd_data(st_rd_data)
    );

    cfg_iter_ctrl #(
        .ITER_W(ITER_W)
    ) u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (iter_start),
        .start_val(iter_val),
        .run      (iter_run),
        .stall    (iter_stall)
    );

    assign busy         = (ctl_q.st != LD_IDLE);
    assign array_run    = iter_run;
    assign array_stall  = iter_stall;
    assign active_id    = ctl_q.act_id;
    assign active_valid = ctl_q.act_vld;
    assign mem_rd_req   = (ctl_q.st == LD_FETCH);
    assign mem_rd_addr  = {ctl_q.id, ctl_q.idx};
    assign cfg_we       = ctl_q.we;
    assign cfg_addr     = ctl_q.waddr;
    assign cfg_wdata    = ctl_q.wdata;

endmodule

// File: rtl/cfg_cache_loader_chk.sv
module cfg_cache_loader_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              array_run,
    input logic              array_stall,
    input logic              mem_rd_req,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              cfg_we
);

    // R2: request and address hold until the transfer completes
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R2: memory is only read during a load
    a_r2_req_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy);

    // R3: an array write always follows a cycle spent loading
    a_r3_write_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> $past(busy));

    // R7: running and stalled exclude each other
    a_r7_run_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(array_run && array_stall));

    // R7: count expiry leads straight into stall
    a_r7_stall_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(array_run) |-> array_stall);

    // R10: nothing is loaded while the array runs
    a_r10_quiet_while_run: assert property (@(posedge clk) disable iff (!rst_n)
        array_run |-> (!mem_rd_req && !cfg_we));

endmodule

bind cfg_cache_loader cfg_cache_loader_chk #(
    .ADDR_W(ID_W + IDXW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .array_run   (array_run),
    .array_stall (array_stall),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr (mem_rd_addr),
    .cfg_we      (cfg_we)
);

// File: tb/cfg_cache_loader_tb.sv
module cfg_cache_loader_tb;

    localparam int ID_W   = 8;
    localparam int ITER_W = 16;
    localparam int WPR    = 12;
    localparam int WORDS  = 48;
    localparam int IDXW   = 6;
    localparam int ROW_W  = 2;
    localparam int BUS_W  = 128;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cmd_valid = 1'b0;
    logic                 cmd_is_start = 1'b0;
    logic [ID_W-1:0]      cmd_cfg_id = '0;
    logic [ROW_W-1:0]     cmd_row_first = '0;
    logic [ROW_W-1:0]     cmd_row_last = '0;
    logic [ITER_W-1:0]    cmd_iter = '0;
    logic                 busy, array_run, array_stall, active_valid;
    logic [ID_W-1:0]      active_id;
    logic                 mem_rd_req;
    logic [ID_W+IDXW-1:0] mem_rd_addr;
    logic                 mem_rd_valid = 1'b0;
    logic [BUS_W-1:0]     mem_rd_data = '0;
    logic                 cfg_we;
    logic [IDXW-1:0]      cfg_addr;
    logic [BUS_W-1:0]     cfg_wdata;

    int total = 0;
    int bad = 0;
    int mem_cnt = 0;
    int mem_err = 0;
    int mem_next = 0;
    int wr_cnt = 0;
    int wr_err = 0;
    int wr_next = 0;
    logic [ID_W-1:0] mon_id = '0;

    always #2 clk = ~clk;

    cfg_cache_loader u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_start(cmd_is_start),
        .cmd_cfg_id(cmd_cfg_id), .cmd_row_first(cmd_row_first), .cmd_row_last(cmd_row_last),
        .cmd_iter(cmd_iter), .busy(busy), .array_run(array_run), .array_stall(array_stall),
        .active_id(active_id), .active_valid(active_valid), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    function automatic logic [BUS_W-1:0] pat(input logic [7:0] id, input logic [5:0] k);
        logic [31:0] w;
        w = {id, 2'b00, k, 16'(int'(k) * 7 + int'(id) * 3)};
        return {w, ~w, w ^ 32'h5A5A_3C3C, w + 32'd1};
    endfunction

    // memory model: one transfer per request, a gap cycle between
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_valid = 1'b0;
        end else if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
        end else if (mem_rd_req) begin
            if (int'(mem_rd_addr[5:0]) != mem_next || mem_rd_addr[13:6] != mon_id)
                mem_err++;
            mem_next++;
            mem_rd_data  = pat(mem_rd_addr[13:6], mem_rd_addr[5:0]);
            mem_rd_valid = 1'b1;
            mem_cnt++;
        end
    end

    // array write monitor
    always @(negedge clk) begin
        if (rst_n && cfg_we) begin
            if (int'(cfg_addr) != wr_next || cfg_wdata != pat(mon_id, cfg_addr))
                wr_err++;
            wr_next = int'(cfg_addr) + 1;
            wr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input bit is_start, input logic [7:0] id, input int first,
                        input int last, input int iter);
        @(negedge clk);
        cmd_valid     = 1'b1;
        cmd_is_start  = is_start;
        cmd_cfg_id    = id;
        cmd_row_first = ROW_W'(first);
        cmd_row_last  = ROW_W'(last);
        cmd_iter      = ITER_W'(iter);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic arm(input logic [7:0] id, input int first);
        mon_id   = id;
        wr_next  = first * WPR;
        mem_next = 0;
        mem_cnt  = 0;
        mem_err  = 0;
        wr_cnt   = 0;
        wr_err   = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] id, input int first, input int last,
                           input int exp_mem, input int exp_wr, input string req);
        arm(id, first);
        send(1'b0, id, first, last, 0);
        wait_idle();
        chk(mem_cnt == exp_mem, req, mem_cnt, exp_mem);
        chk(mem_err == 0, "R2 addr order", mem_err, 0);
        chk(wr_cnt == exp_wr, req, wr_cnt, exp_wr);
        chk(wr_err == 0, "R3 write addr/data", wr_err, 0);
        chk(active_id == id && active_valid, "R10 active id", active_id, id);
    endtask

    task automatic t_reset();
        chk(!busy && !array_run && !array_stall, "R1 status low", busy, 0);
        chk(!cfg_we && !mem_rd_req && !active_valid, "R1 ports low", cfg_we, 0);
    endtask

    task automatic t_miss_then_hit();
        do_load(8'h11, 0, 3, WORDS, WORDS, "R1 R2 first load full miss");
        do_load(8'h11, 1, 2, 0, 2 * WPR, "R4 R3 partial hit");
        do_load(8'h22, 2, 2, WORDS, WPR, "R2 R3 partial miss");
        do_load(8'h11, 3, 1, 0, 0, "R3 empty range");
    endtask

    task automatic t_replace();
        do_load(8'h33, 0, 3, WORDS, WORDS, "R5 fill slot2");
        do_load(8'h44, 0, 3, WORDS, WORDS, "R5 fill slot3");
        do_load(8'h11, 0, 0, 0, WPR, "R5 hit keeps order");
        do_load(8'h55, 0, 3, WORDS, WORDS, "R5 miss evicts oldest");
        do_load(8'h11, 0, 3, WORDS, WORDS, "R5 oldest was evicted");
        do_load(8'h33, 0, 3, 0, WORDS, "R5 younger slot kept");
        do_load(8'h22, 0, 3, WORDS, WORDS, "R5 second oldest evicted");
    endtask

    task automatic t_run(input int n);
        int cnt = 0;
        bit first_ok = 0;
        bit end_ok = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_start = 1'b1; cmd_iter = ITER_W'(n);
        for (int k = 1; k <= n + 4; k++) begin
            @(negedge clk);
            if (k == 1) begin
                cmd_valid = 1'b0;
                first_ok = (n == 0) ? (!array_run && array_stall) : (array_run && !array_stall);
            end
            if (array_run) cnt++;
            if (k == n + 1) end_ok = !array_run && array_stall;
        end
        if (n == 0) begin
            chk(first_ok, "R8 zero count stalls next cycle", array_stall, 1);
            chk(cnt == 0, "R8 zero count never runs", cnt, 0);
        end else begin
            chk(first_ok, "R7 run begins next cycle", array_run, 1);
            chk(cnt == n, "R7 run length", cnt, n);
            chk(end_ok, "R7 stall after expiry", array_stall, 1);
        end
    endtask

    task automatic t_start_during_load();
        int cnt = 0;
        bit early = 0;
        arm(8'h66, 0);
        send(1'b0, 8'h66, 0, 3, 0);
        repeat (4) @(negedge clk);
        send(1'b1, 8'h00, 0, 0, 5);
        while (busy) begin
            if (array_run) early = 1;
            @(negedge clk);
        end
        chk(!early, "R9 held start waits for load", early, 0);
        for (int k = 0; k < 12; k++) begin
            if (array_run) cnt++;
            @(negedge clk);
        end
        chk(cnt == 5, "R9 held start runs full count", cnt, 5);
    endtask

    task automatic t_load_while_busy();
        arm(8'h77, 0);
        send(1'b0, 8'h77, 0, 3, 0);
        repeat (3) @(negedge clk);
        send(1'b0, 8'h11, 0, 3, 0);
        wait_idle();
        chk(mem_cnt == WORDS && mem_err == 0, "R6 second load ignored", mem_cnt, WORDS);
        chk(active_id == 8'h77, "R6 active id kept", active_id, 8'h77);
    endtask

    task automatic t_load_while_run();
        logic [7:0] prev;
        prev = active_id;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_start = 1'b1; cmd_iter = ITER_W'(30);
        @(negedge clk);
        cmd_valid = 1'b0;
        arm(8'h99, 0);
        repeat (2) @(negedge clk);
        send(1'b0, 8'h99, 0, 3, 0);
        repeat (4) @(negedge clk);
        chk(!busy && mem_cnt == 0, "R10 load ignored while running", mem_cnt, 0);
        chk(wr_cnt == 0, "R10 no writes while running", wr_cnt, 0);
        chk(active_id == prev, "R10 active id unchanged", active_id, prev);
        repeat (30) @(negedge clk);
        chk(array_stall, "R7 stall after long run", array_stall, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_replace();
        t_run(7);
        t_run(0);
        t_run(2);
        t_start_during_load();
        t_load_while_busy();
        t_load_while_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule